// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the series of column addresses a DDR2-style memory array visits during a read or write burst. A single-cycle start strobe carries a 10-bit starting column, a length select and an ordering select. On the following cycles the block presents one column address per beat, together with a valid flag and a flag that marks the final beat. It works per beat, not per clock edge. The surrounding controller pairs each beat with the two data transfers of a double-data-rate clock.

Two beat orderings are available at both lengths. The sequential order counts up through the low address bits and wraps inside the aligned block. The interleaved order XORs the low bits of the start column with the beat number. A burst of four stays inside one aligned group of four columns, which matches the four-word prefetch of the array. A burst of eight covers two such groups inside an aligned block of eight. Command decode, latency timing and the strobe/data pins belong to other blocks.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `valid_o` and `last_o` are 0.
- R2: A start (`start_i`=1) is taken when `valid_o` is 0 or `last_o` is 1. The first beat then shows on the next cycle with `valid_o`=1 and `col_o` equal to the sampled `start_col_i`. When the start arrives with `last_o`=1, the new burst follows the old one with no gap.
- R3: `bl8_i`=0 gives a burst of 4 beats and `bl8_i`=1 gives 8 beats. Beats follow on consecutive cycles with `valid_o` held at 1.
- R4: With `ilv_i`=0 and 4 beats, beat n has low 2 bits equal to (start[1:0]+n) mod 4. Bits 9:2 stay equal to those of the start column.
- R5: With `ilv_i`=0 and 8 beats, beat n has low 3 bits equal to (start[2:0]+n) mod 8. Bits 9:3 stay equal to those of the start column.
- R6: With `ilv_i`=1, beat n is the start column with its low 2 bits (4 beats) or low 3 bits (8 beats) XORed with n. All other bits are unchanged.
- R7: `last_o` is 1 only on the final beat: beat 3 of a 4-beat burst and beat 7 of an 8-beat burst.
- R8: A start that arrives while `valid_o`=1 and `last_o`=0 is ignored. The running burst keeps its addresses and its length.
- R9: Length and ordering are sampled with the accepted start. Changes to `bl8_i` and `ilv_i` during the burst have no effect on it.
- R10: When the final beat has been issued and no start is taken, `valid_o` falls to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | 10 | Starting column address |
| bl8_i | input | 1 | Length select: 0 = 4 beats, 1 = 8 beats |
| ilv_i | input | 1 | Ordering select: 0 = sequential, 1 = interleaved |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
A wrong beat counter would move `last_o` off beat 3 or beat 7. It would also make the burst end early or run on, and the port shows this within the same burst. A wrong latched mode or base column shows up at the ports on the first beat after the start: either the upper address bits drift, or the low bits step in the wrong order. Both appear within at most eight cycles of the start that loaded the bad state. A bad acceptance rule shows at once as a restarted burst or a missing gap, and the bench compares every cycle against its own queue of expected beats.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // beat index width for the longest burst (8 beats)
  localparam int BEAT_W = 3;

  typedef enum logic {
    BL_FOUR  = 1'b0,
    BL_EIGHT = 1'b1
  } burst_len_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } burst_ord_e;

  typedef struct packed {
    burst_len_e len;
    burst_ord_e ord;
  } burst_mode_t;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = BEAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  burst_len_e       len_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] FINAL_LONG  = CNT_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] FINAL_SHORT = CNT_W'((1 << (CNT_W - 1)) - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  burst_len_e       len_q,  len_d;
  logic             en;
  logic             at_final;

  assign at_final = busy_q && (beat_q == ((len_q == BL_EIGHT) ? FINAL_LONG : FINAL_SHORT));
  assign en       = load_i || busy_q;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    len_d  = len_q;
    if (load_i) begin
      busy_d = 1'b1;
      beat_d = '0;
      len_d  = len_i;
    end else if (at_final) begin
      busy_d = 1'b0;
      beat_d = '0;
    end else if (busy_q) begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      len_q  <= BL_FOUR;
    end else if (en) begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      len_q  <= len_d;
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;
  assign last_o = at_final;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LOW_W = BEAT_W
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [LOW_W-1:0] beat_i,
  input  burst_mode_t      mode_i,
  output logic [COL_W-1:0] col_o
);
  localparam int HI_W = COL_W - LOW_W;

  logic [LOW_W-1:0] sum_low;
  logic [LOW_W-1:0] wrap_mask;
  logic [LOW_W-1:0] seq_low;
  logic [LOW_W-1:0] xor_low;
  logic [LOW_W-1:0] sel_low;

  // lower bits always wrap with the sum; the top low bit only for long bursts
  generate
    for (genvar b = 0; b < LOW_W; b++) begin : g_mask
      if (b == LOW_W - 1) begin : g_top
        assign wrap_mask[b] = (mode_i.len == BL_EIGHT);
      end else begin : g_low
        assign wrap_mask[b] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    sum_low = base_i[LOW_W-1:0] + beat_i;
    seq_low = (base_i[LOW_W-1:0] & ~wrap_mask) | (sum_low & wrap_mask);
    xor_low = base_i[LOW_W-1:0] ^ beat_i;
    sel_low = (mode_i.ord == ORD_XOR) ? xor_low : seq_low;
  end

  assign col_o = {base_i[COL_W-1 -: HI_W], sel_low};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             bl8_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic              busy;
  logic              at_last;
  logic              take;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  base_q, base_d;
  burst_mode_t       mode_q, mode_d;
  burst_mode_t       req_mode;

  assign req_mode.len = burst_len_e'(bl8_i);
  assign req_mode.ord = burst_ord_e'(ilv_i);

  // accept when idle or on the final beat
  assign take = start_i && (!busy || at_last);

  always_comb begin
    base_d = base_q;
    mode_d = mode_q;
    if (take) begin
      base_d = start_col_i;
      mode_d = req_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= '{len: BL_FOUR, ord: ORD_SEQ};
    end else if (take) begin
      base_q <= base_d;
      mode_q <= mode_d;
    end
  end

  burst_beat_ctr #(.CNT_W(BEAT_W)) ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (take),
    .len_i  (req_mode.len),
    .busy_o (busy),
    .beat_o (beat),
    .last_o (at_last)
  );

  burst_addr_gen #(.COL_W(COL_W), .LOW_W(BEAT_W)) agen_i (
    .base_i (base_q),
    .beat_i (beat),
    .mode_i (mode_q),
    .col_o  (col_o)
  );

  assign valid_o = busy;
  assign last_o  = at_last;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             bl8_i,
  input logic             ilv_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic             ck_take;
  logic [3:0]       ck_beat;
  logic             ck_bl8;
  logic             ck_ilv;
  logic [COL_W-1:0] ck_base;

  assign ck_take = start_i && (!valid_o || last_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_beat <= '0;
      ck_bl8  <= 1'b0;
      ck_ilv  <= 1'b0;
      ck_base <= '0;
    end else if (ck_take) begin
      ck_beat <= '0;
      ck_bl8  <= bl8_i;
      ck_ilv  <= ilv_i;
      ck_base <= start_col_i;
    end else if (valid_o) begin
      ck_beat <= ck_beat + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !valid_o && !last_o);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_take |=> valid_o && (col_o == $past(start_col_i)));

  // R3
  burst_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> valid_o);

  // R7
  last_beat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (last_o == (ck_beat == (ck_bl8 ? 4'd7 : 4'd3))));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));

  // R6
  xor_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ck_ilv |-> col_o == (ck_base ^ {{(COL_W-3){1'b0}}, ck_beat[2:0]}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o || last_o) && !start_i |=> !valid_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bl8_i       (bl8_i),
  .ilv_i       (ilv_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/100ps
module burst_col_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [9:0] start_col_i;
  logic       bl8_i;
  logic       ilv_i;
  logic [9:0] col_o;
  logic       valid_o;
  logic       last_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;
  int    exp_q[$];

  burst_col_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl8_i(bl8_i), .ilv_i(ilv_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int beat_addr(int start, int n, bit long_b, bit xor_b);
    int msk;
    msk = long_b ? 7 : 3;
    if (xor_b) return start ^ n;
    return (start & ~msk) | ((start + n) & msk);
  endfunction

  // reference: queue front is the beat on the outputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
    end else begin
      bit can_take;
      can_take = (exp_q.size() <= 1);
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      if (can_take && start_i) begin
        for (int n = 0; n < (bl8_i ? 8 : 4); n++)
          exp_q.push_back(beat_addr(int'(start_col_i), n, bl8_i, ilv_i));
      end
    end
  end

  task automatic check(string req, bit ok, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = (exp_q.size() > 0);
      check(cur_req, valid_o == ev, int'(valid_o), int'(ev), "valid");
      if (ev) begin
        check(cur_req, int'(col_o) == exp_q[0], int'(col_o), exp_q[0], "col");
        check(cur_req, last_o == (exp_q.size() == 1), int'(last_o),
              int'(exp_q.size() == 1), "last (R7)");
      end else begin
        check(cur_req, last_o == 1'b0, int'(last_o), 0, "last idle");
      end
    end
  end

  task automatic drive(bit st, int col, bit l8, bit xo);
    @(negedge clk);
    #1;
    start_i = st; start_col_i = 10'(col); bl8_i = l8; ilv_i = xo;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 0; start_col_i = 0; bl8_i = 0; ilv_i = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", !valid_o && !last_o, int'({valid_o, last_o}), 0, "reset outputs");
    #1 rst_n = 1'b1;
    idle(2);
    cur_req = "R4"; drive(1, 'h2A6, 0, 0); idle(6);
    cur_req = "R5"; drive(1, 'h15D, 1, 0); idle(10);
    cur_req = "R6"; drive(1, 'h0B5, 0, 1); idle(6);
    drive(1, 'h2F3, 1, 1); idle(10);
    // R9: change mode pins mid-burst
    cur_req = "R9"; drive(1, 'h107, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 'h3FF, 1, 1);
    idle(4);
    // R8: new start mid-burst is ignored
    cur_req = "R8"; drive(1, 'h04A, 1, 0);
    for (int i = 0; i < 4; i++) drive(1, 'h3C1, 0, 1);
    idle(8);
    // R2/R3: start held high gives back-to-back bursts
    cur_req = "R2";
    for (int i = 0; i < 20; i++) drive(1, 'h1E0 + i, i[0], i[1]);
    cur_req = "R10"; idle(12);
    cur_req = "R3";
    for (int i = 0; i < 400; i++)
      drive(($urandom % 3) == 0, int'($urandom % 1024), 1'($urandom), 1'($urandom));
    idle(10);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule